// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block holds the interrupt state of one hardware thread across four privilege rings: user, OS, pool and physical. Each ring keeps an 8-bit pending buffer and an 8-bit current priority. A router presents events as a pair of ring and priority. Each event sets one bit in that ring's pending buffer. Whenever the most favoured pending priority of a ring is numerically below its current priority, the ring is in exception. The result reaches one of two exception lines: one for the hypervisor level and one for the OS level.

Software reaches the context through a register port. Every access carries a page code that states its privilege, a ring, a field and write data. Reading the acknowledge field takes the most favoured pending priority. That read clears its pending bit and raises the current priority to the same level, so the exception line drops. Accesses that the page lacks the privilege for are dropped: a denied write has no effect and a denied read returns zero.

Top module: `tic_thread_ctx`

## Requirements
- R1: After reset, every pending buffer reads 0x00, every current priority reads 0xFF, and both exception lines are low.
- R2: A presented priority p in 0..7 sets bit (7 - p) of the addressed ring's pending buffer, OR-ed with the bits already there. A presented priority above 7 leaves the buffer unchanged.
- R3: A ring is in exception when its pending buffer is non-zero and its most favoured (lowest) pending priority is numerically below its current priority. Ring codes are user 0, OS 1, pool 2 and physical 3. `osIrq` is the OR of the user and OS rings, and `hvIrq` is the OR of the pool and physical rings.
- R4: The exception lines are registered. They reflect the state produced by a clock edge at the following edge, so they change two edges after the stimulus is sampled.
- R5: A read of field code 2 (acknowledge) on a ring that is in exception returns its most favoured pending priority, clears that bit and sets the current priority to that value. On a ring not in exception it returns 0xFF and changes nothing.
- R6: Field code 1 is the current priority: a permitted write stores the 8-bit write data and a permitted read returns it. Field code 0 is the pending buffer and a permitted read returns it.
- R7: Page codes are hardware 0, hypervisor 1, OS 2 and user 3. A page may reach a ring only when ring code + page code is at most 3. An access to an unreachable ring reads 0x00 and changes no state, and this applies to acknowledge reads as well.
- R8: Pending-buffer writes take effect only from the hardware page, and current-priority writes from any page except user. Field code 3 always reads 0x00. Writes to field codes 2 and 3 are ignored.
- R9: When a register operation and a presentation target the same ring in the same cycle, the register operation is applied first and the presented bit is OR-ed into the result.
- R10: `regRvalid` is high for exactly one cycle, on the edge after a read is sampled, and `regRdata` carries the result in that cycle. In other cycles `regRdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| presentValid | input | 1 | Presentation request strobe |
| presentRing | input | 2 | Ring of the presentation |
| presentPrio | input | 8 | Priority of the presentation |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regPage | input | 2 | Privilege page of the access |
| regRing | input | 2 | Ring addressed |
| regField | input | 2 | Field: 0 pending, 1 current priority, 2 acknowledge, 3 reserved |
| regWdata | input | 8 | Write data |
| regRvalid | output | 1 | Read result valid |
| regRdata | output | 8 | Read result |
| hvIrq | output | 1 | Hypervisor-level exception line |
| osIrq | output | 1 | OS-level exception line |

## Verification
Read results appear one edge after the read is sampled. A state change caused by a presentation or a write appears on the exception lines one edge later still. The bench therefore reads results at the falling edge right after the operation's cycle. It checks the line one idle cycle later, and it also checks the line at the first falling edge, where it must not have moved yet. A behavioural model advances on the same rising edge as the design and is compared at every falling edge. Each output is checked in the cycle where the requirements say it is due, which covers every latency in both the directed and the random phases.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int PRIO_W      = 8;
  localparam int ACTIVE_LVLS = 8;
  localparam int RING_CNT    = 4;
  localparam int RING_W      = $clog2(RING_CNT);
  localparam int PAGE_W      = 2;
  localparam int FIELD_W     = 2;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;

  localparam int RING_USER = 0;
  localparam int RING_OS   = 1;
  localparam int RING_POOL = 2;
  localparam int RING_PHYS = 3;

  localparam logic [PAGE_W-1:0] PAGE_HW   = 2'd0;
  localparam logic [PAGE_W-1:0] PAGE_USER = 2'd3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_PEND = 2'd0,
    FLD_CPPR = 2'd1,
    FLD_ACK  = 2'd2,
    FLD_RSVD = 2'd3
  } field_e;

  typedef struct packed {
    logic              rdAny;
    logic              wrPend;
    logic              wrCppr;
    logic              ackRd;
    logic              rdPend;
    logic              rdCppr;
    logic [RING_W-1:0] ring;
    logic [PRIO_W-1:0] wdata;
  } ctxStrobe_t;
endpackage

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
(
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [PAGE_W-1:0]  regPage,
  input  logic [RING_W-1:0]  regRing,
  input  logic [FIELD_W-1:0] regField,
  input  logic [PRIO_W-1:0]  regWdata,
  output ctxStrobe_t         strb
);
  localparam int SUM_W = (RING_W > PAGE_W ? RING_W : PAGE_W) + 1;

  logic [SUM_W-1:0] privSum;
  logic             reachable;
  logic             isRead;
  logic             isWrite;
  field_e           fld;

  assign privSum   = SUM_W'(regRing) + SUM_W'(regPage);
  assign reachable = privSum <= SUM_W'(RING_CNT - 1);
  assign isRead    = regValid && !regWrite;
  assign isWrite   = regValid && regWrite;
  assign fld       = field_e'(regField);

  always_comb begin
    strb        = '0;
    strb.ring   = regRing;
    strb.wdata  = regWdata;
    strb.rdAny  = isRead;
    strb.wrPend = isWrite && (fld == FLD_PEND) && (regPage == PAGE_HW);
    strb.wrCppr = isWrite && (fld == FLD_CPPR) && reachable && (regPage != PAGE_USER);
    strb.ackRd  = isRead && (fld == FLD_ACK) && reachable;
    strb.rdPend = isRead && (fld == FLD_PEND) && reachable;
    strb.rdCppr = isRead && (fld == FLD_CPPR) && reachable;
  end
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
  import tic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctxStrobe_t        strb,
  input  logic              presentValid,
  input  logic [RING_W-1:0] presentRing,
  input  logic [PRIO_W-1:0] presentPrio,
  output logic              regRvalid,
  output logic [PRIO_W-1:0] regRdata,
  output logic              hvIrq,
  output logic              osIrq
);
  function automatic logic [PRIO_W-1:0] bestPrio(input logic [ACTIVE_LVLS-1:0] bits);
    logic [PRIO_W-1:0] best;
    best = PRIO_LEAST;
    for (int i = ACTIVE_LVLS - 1; i >= 0; i--) begin
      if (bits[ACTIVE_LVLS-1-i]) best = PRIO_W'(i);
    end
    return best;
  endfunction

  function automatic logic [ACTIVE_LVLS-1:0] prioMask(input logic [PRIO_W-1:0] p);
    logic [ACTIVE_LVLS-1:0] m;
    for (int i = 0; i < ACTIVE_LVLS; i++) begin
      m[ACTIVE_LVLS-1-i] = (p == PRIO_W'(i));
    end
    return m;
  endfunction

  logic [RING_CNT-1:0][ACTIVE_LVLS-1:0] pendView;
  logic [RING_CNT-1:0][PRIO_W-1:0]      cpprView;
  logic [RING_CNT-1:0][PRIO_W-1:0]      topView;
  logic [RING_CNT-1:0]                  excNow;

  for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
    logic                   sel;
    logic                   hit;
    logic [ACTIVE_LVLS-1:0] pendQ;
    logic [ACTIVE_LVLS-1:0] pendNext;
    logic [PRIO_W-1:0]      cpprQ;
    logic [PRIO_W-1:0]      cpprNext;
    logic [PRIO_W-1:0]      top;

    assign sel       = strb.ring == RING_W'(r);
    assign hit       = presentValid && (presentRing == RING_W'(r));
    assign top       = bestPrio(pendQ);
    assign excNow[r] = (pendQ != '0) && (top < cpprQ);

    always_comb begin
      pendNext = pendQ;
      cpprNext = cpprQ;
      if (sel && strb.wrPend) pendNext = strb.wdata[ACTIVE_LVLS-1:0];
      if (sel && strb.wrCppr) cpprNext = strb.wdata;
      if (sel && strb.ackRd && excNow[r]) begin
        pendNext = pendNext & ~prioMask(top);
        cpprNext = top;
      end
      if (hit) pendNext = pendNext | prioMask(presentPrio);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ <= '0;
        cpprQ <= PRIO_LEAST;
      end else begin
        pendQ <= pendNext;
        cpprQ <= cpprNext;
      end
    end

    assign pendView[r] = pendQ;
    assign cpprView[r] = cpprQ;
    assign topView[r]  = top;
  end

  logic [PRIO_W-1:0] ackResult;
  logic [PRIO_W-1:0] rdNext;

  assign ackResult = excNow[strb.ring] ? topView[strb.ring] : PRIO_LEAST;

  always_comb begin
    rdNext = '0;
    if (strb.rdPend)      rdNext = PRIO_W'(pendView[strb.ring]);
    else if (strb.rdCppr) rdNext = cpprView[strb.ring];
    else if (strb.ackRd)  rdNext = ackResult;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hvIrq     <= 1'b0;
      osIrq     <= 1'b0;
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      hvIrq     <= excNow[RING_POOL] | excNow[RING_PHYS];
      osIrq     <= excNow[RING_USER] | excNow[RING_OS];
      regRvalid <= strb.rdAny;
      regRdata  <= rdNext;
    end
  end
endmodule

// File: rtl/tic_thread_ctx.sv
module tic_thread_ctx
  import tic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               presentValid,
  input  logic [RING_W-1:0]  presentRing,
  input  logic [PRIO_W-1:0]  presentPrio,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [PAGE_W-1:0]  regPage,
  input  logic [RING_W-1:0]  regRing,
  input  logic [FIELD_W-1:0] regField,
  input  logic [PRIO_W-1:0]  regWdata,
  output logic               regRvalid,
  output logic [PRIO_W-1:0]  regRdata,
  output logic               hvIrq,
  output logic               osIrq
);
  ctxStrobe_t strb;

  tic_ctrl u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regPage  (regPage),
    .regRing  (regRing),
    .regField (regField),
    .regWdata (regWdata),
    .strb     (strb)
  );

  tic_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .presentValid (presentValid),
    .presentRing  (presentRing),
    .presentPrio  (presentPrio),
    .regRvalid    (regRvalid),
    .regRdata     (regRdata),
    .hvIrq        (hvIrq),
    .osIrq        (osIrq)
  );
endmodule

// File: rtl/tic_checker.sv
module tic_checker
  import tic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic [PAGE_W-1:0]  regPage,
  input logic [RING_W-1:0]  regRing,
  input logic [FIELD_W-1:0] regField,
  input logic               regRvalid,
  input logic [PRIO_W-1:0]  regRdata,
  input logic               hvIrq,
  input logic               osIrq,
  input ctxStrobe_t         strb
);
  logic deniedRead;
  assign deniedRead = regValid && !regWrite &&
                      ((3'(regRing) + 3'(regPage)) > 3'(RING_CNT - 1));

  // R1
  resetQuiet_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!hvIrq && !osIrq && !regRvalid));

  // R7
  deniedRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    deniedRead |=> (regRvalid && regRdata == '0));

  // R8
  userNoWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regPage == PAGE_USER) |-> (!strb.wrPend && !strb.wrCppr));

  // R5
  ackRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackRd |=> (regRdata < PRIO_W'(ACTIVE_LVLS) || regRdata == PRIO_LEAST));

  // R10
  readValid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> regRvalid);

  // R10
  writeQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> (!regRvalid && regRdata == '0));

  // R8
  rsvdZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regField == 2'd3) |=> (regRdata == '0));
endmodule

bind tic_thread_ctx tic_checker u_chk (.*);

// File: tb/test_tic_thread_ctx.sv
module test_tic_thread_ctx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       presentValid = 1'b0;
  logic [1:0] presentRing = '0;
  logic [7:0] presentPrio = '0;
  logic       regValid = 1'b0;
  logic       regWrite = 1'b0;
  logic [1:0] regPage = '0;
  logic [1:0] regRing = '0;
  logic [1:0] regField = '0;
  logic [7:0] regWdata = '0;
  logic       regRvalid;
  logic [7:0] regRdata;
  logic       hvIrq;
  logic       osIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tic_thread_ctx i_tic_thread_ctx (.*);

  // behavioural reference model
  int  mPend[4];
  int  mCppr[4];
  bit  mHv, mOs, mRv;
  int  mRd;
  int  mTop[4];
  bit  mExc[4];
  bit  mReach;

  function automatic int topOf(int b);
    for (int p = 0; p < 8; p++) if (b[7-p]) return p;
    return 255;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < 4; r++) begin mPend[r] = 0; mCppr[r] = 255; end
      mHv = 0; mOs = 0; mRv = 0; mRd = 0;
    end else begin
      for (int r = 0; r < 4; r++) begin
        mTop[r] = topOf(mPend[r]);
        mExc[r] = (mPend[r] != 0) && (mTop[r] < mCppr[r]);
      end
      mHv = mExc[2] | mExc[3];
      mOs = mExc[0] | mExc[1];
      mReach = (int'(regRing) + int'(regPage)) <= 3;
      mRv = regValid && !regWrite;
      mRd = 0;
      if (regValid && !regWrite && mReach) begin
        case (regField)
          2'd0: mRd = mPend[regRing];
          2'd1: mRd = mCppr[regRing];
          2'd2: mRd = mExc[regRing] ? mTop[regRing] : 255;
          default: mRd = 0;
        endcase
      end
      if (regValid && regWrite && regField == 2'd0 && regPage == 2'd0)
        mPend[regRing] = int'(regWdata);
      if (regValid && regWrite && regField == 2'd1 && mReach && regPage != 2'd3)
        mCppr[regRing] = int'(regWdata);
      if (regValid && !regWrite && regField == 2'd2 && mReach && mExc[regRing]) begin
        mPend[regRing] = mPend[regRing] & ~(1 << (7 - mTop[regRing]));
        mCppr[regRing] = mTop[regRing];
      end
      if (presentValid && presentPrio <= 8'd7)
        mPend[presentRing] = mPend[presentRing] | (1 << (7 - int'(presentPrio)));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R3 hvIrq model", int'(hvIrq), int'(mHv));
      check("R3 osIrq model", int'(osIrq), int'(mOs));
      check("R10 regRvalid model", int'(regRvalid), int'(mRv));
      check("R6 regRdata model", int'(regRdata), mRd);
    end
  end

  task automatic step(input bit pv, input logic [1:0] pr, input logic [7:0] pp,
                      input bit rv, input bit wr, input logic [1:0] pg,
                      input logic [1:0] rg, input logic [1:0] fd, input logic [7:0] wd);
    presentValid = pv; presentRing = pr; presentPrio = pp;
    regValid = rv; regWrite = wr; regPage = pg; regRing = rg; regField = fd; regWdata = wd;
    @(posedge clk);
    @(negedge clk);
    presentValid = 0; regValid = 0; regWrite = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic present(input logic [1:0] rg, input logic [7:0] p);
    step(1, rg, p, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] pg, input logic [1:0] rg, input logic [1:0] fd);
    step(0, 0, 0, 1, 0, pg, rg, fd, 0);
  endtask

  task automatic wr(input logic [1:0] pg, input logic [1:0] rg, input logic [1:0] fd,
                    input logic [7:0] wd);
    step(0, 0, 0, 1, 1, pg, rg, fd, wd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 hvIrq", int'(hvIrq), 0);
    check("R1 osIrq", int'(osIrq), 0);
    rd(0, 1, 1); check("R1 cppr", int'(regRdata), 'hFF);
    rd(0, 2, 0); check("R1 pending", int'(regRdata), 0);

    // R2 encoding, R4 timing, R3 condition
    present(1, 3);
    check("R4 osIrq not yet", int'(osIrq), 0);
    idle();
    check("R3 osIrq raised", int'(osIrq), 1);
    check("R3 hvIrq quiet", int'(hvIrq), 0);
    rd(0, 1, 0); check("R2 prio3 bit", int'(regRdata), 'h10);
    present(1, 8'd200);
    rd(0, 1, 0); check("R2 prio above 7", int'(regRdata), 'h10);
    present(1, 1);
    rd(0, 1, 0); check("R2 OR-in", int'(regRdata), 'h50);

    // R5 acknowledge
    rd(2, 1, 2); check("R5 ack value", int'(regRdata), 1);
    check("R10 rvalid", int'(regRvalid), 1);
    idle();
    check("R5 line dropped", int'(osIrq), 0);
    rd(2, 1, 1); check("R5 cppr after ack", int'(regRdata), 1);
    rd(0, 1, 0); check("R5 bit cleared", int'(regRdata), 'h10);

    // R6 cppr write
    wr(2, 1, 1, 5);
    check("R10 no rvalid on write", int'(regRvalid), 0);
    check("R4 line not yet", int'(osIrq), 0);
    idle();
    check("R6 line after cppr", int'(osIrq), 1);

    // R7 / R8 privilege
    rd(3, 1, 0); check("R7 user page other ring", int'(regRdata), 0);
    rd(2, 2, 1); check("R7 OS page pool ring", int'(regRdata), 0);
    wr(3, 0, 1, 0);
    rd(0, 0, 1); check("R8 user cppr write ignored", int'(regRdata), 'hFF);
    wr(2, 1, 0, 'hFF);
    rd(0, 1, 0); check("R8 OS pending write ignored", int'(regRdata), 'h10);
    rd(0, 1, 3); check("R8 reserved field", int'(regRdata), 0);

    // hypervisor line
    present(3, 7);
    idle();
    check("R3 hvIrq raised", int'(hvIrq), 1);
    rd(1, 3, 2); check("R7 denied ack", int'(regRdata), 0);
    idle();
    check("R7 denied ack no effect", int'(hvIrq), 1);
    rd(0, 3, 2); check("R5 ack phys", int'(regRdata), 7);
    idle();
    check("R5 hvIrq dropped", int'(hvIrq), 0);
    rd(0, 3, 2); check("R5 ack when idle", int'(regRdata), 'hFF);

    // R9 same-cycle ordering
    step(1, 1, 3, 1, 0, 2, 1, 2, 0);
    check("R9 ack with present", int'(regRdata), 3);
    rd(0, 1, 0); check("R9 pending re-set", int'(regRdata), 'h10);
    step(1, 0, 0, 1, 1, 0, 0, 0, 'h01);
    rd(0, 0, 0); check("R9 write then OR", int'(regRdata), 'h81);
    idle();
    check("R3 user ring on osIrq", int'(osIrq), 1);

    // random phase, compared to the model every cycle
    for (int n = 0; n < 2000; n++) begin
      step(1'($urandom), 2'($urandom), (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 8),
           1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           (($urandom % 2) == 0) ? 8'($urandom % 10) : 8'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule